// File: doc/BRIEF.md
# Exception Entry Vector Generator

This block turns an already prioritised exception request into the processor's exception entry state. When a request is accepted it saves the return PC and the branch-delay flag, unless an exception is already being handled. It then sets the exception-level flag, records a 5-bit cause code and produces the handler fetch address. That address is made from a handler base and an offset picked by the exception class, the refill condition, the boot-vector flag and the programmable spacing of vectored interrupts.

The surrounding pipeline presents one request per cycle on `reqValid` together with the request's attributes. A small write port loads the handler base, the status fields (exception level, boot-vector flag, interrupt mask) and the vectored-interrupt controls. Results appear one clock edge after the request, together with a single-cycle `takenPulse`.

Top module: `exc_vector_gen`

## Requirements
- R1: After reset `takenPulse`, `excLevel`, `branchDelay`, `excCode`, `epc` and `handlerAddr` are all zero. The handler base resets to 0x80000000, the boot-vector flag resets to 1, and the interrupt mask, vectored-interrupt enable and spacing reset to 0.
- R2: `reqType` is encoded as 0 interrupt, 1 TLB modify, 2 TLB miss/invalid, 3 address fault, 4 syscall, 5 break, 6 reserved instruction, 7 overflow, 8 trap and 9 cache error; codes 10 to 15 are treated as reserved instruction. The recorded `excCode` is 0, 1, 2/3, 4/5, 8, 9, 10, 12, 13 and 30 in that order. For types 2 and 3 the store form (3 or 5) is used when `reqStore` is 1.
- R3: `epc` and `branchDelay` are updated only when `excLevel` is 0 at the accepting edge. A request with `reqDelaySlot`=1 saves `reqPc`-4 and sets `branchDelay`; otherwise it saves `reqPc` and clears it. With `excLevel`=1 both keep their values.
- R4: Every accepted request sets `excLevel`. A status write (`cfgSel`=1) loads `excLevel` from data bit 0. On a cycle with both a request and a status write, the request's setting wins.
- R5: With the boot-vector flag clear, the handler base is the base register with its low 12 bits cleared, and the default offset is 0x180.
- R6: A type-2 request with `reqNoMatch`=1, accepted while `excLevel` is 0, uses offset 0x000. Otherwise it uses 0x180.
- R7: An interrupt with the vectored enable set uses offset 0x200 when the boot-vector flag is set or the spacing is 0. Otherwise it uses 0x200 + v*(spacing*32). Here v is the index of the highest set bit of `irqPending` AND mask, and v is 0 when no bit is set. An interrupt with the enable clear uses 0x180.
- R8: A cache error uses offset 0x100 on the base 0xA0000000 OR (base register bits 28:12, kept in place).
- R9: With the boot-vector flag set, every class uses the base 0xBFC00200, and the class offset is added to it.
- R10: All results are registered on the edge that accepts the request, and `takenPulse` is 1 for exactly the cycle after each accepted request.
- R11: Write port layout: `cfgSel`=0 loads the base from data bits 31:12. `cfgSel`=1 loads exception level (bit 0), boot-vector flag (bit 1) and interrupt mask (bits 15:8). `cfgSel`=2 loads the vectored enable (bit 0) and spacing (bits 9:5). `cfgSel`=3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Exception request accepted this cycle |
| reqType | input | 4 | Exception class (R2 encoding) |
| reqStore | input | 1 | Faulting access was a store |
| reqNoMatch | input | 1 | TLB fault had no matching entry |
| reqPc | input | 32 | PC of the faulting instruction |
| reqDelaySlot | input | 1 | Faulting instruction sits in a branch delay slot |
| irqPending | input | 8 | Pending interrupt lines |
| cfgWe | input | 1 | Control register write strobe |
| cfgSel | input | 2 | Control register select |
| cfgData | input | 32 | Control register write data |
| epc | output | 32 | Saved exception return PC |
| branchDelay | output | 1 | Saved delay-slot flag |
| excLevel | output | 1 | Exception level flag |
| excCode | output | 5 | Recorded exception code |
| handlerAddr | output | 32 | Handler fetch address |
| takenPulse | output | 1 | One-cycle pulse after an accepted request |

## Verification
The assertions assume that `reqValid` is never X after reset and that `reqType` uses only the classes listed in R2. They also assume that a status write does not share a cycle with a request. The bench produces only legal type codes, and it issues control writes and requests in separate cycles. It clears the exception level through the write port at random, so that both the frozen-PC path and the refill path are reached.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [3:0] {
    TY_IRQ      = 4'd0,
    TY_TLB_MOD  = 4'd1,
    TY_TLB_FLT  = 4'd2,
    TY_ADDR_FLT = 4'd3,
    TY_SYSCALL  = 4'd4,
    TY_BREAK    = 4'd5,
    TY_RESV     = 4'd6,
    TY_OVF      = 4'd7,
    TY_TRAP     = 4'd8,
    TY_CACHE    = 4'd9
  } exc_type_e;

  typedef enum logic [1:0] {
    OFF_GENERAL,
    OFF_REFILL,
    OFF_CACHE,
    OFF_IRQ
  } off_sel_e;

  typedef struct packed {
    logic     take;
    logic     saveEpc;
    logic [4:0] code;
    off_sel_e offSel;
  } exc_strobe_t;

  localparam logic [31:0] UNCACHED_BASE = 32'hA000_0000;
  localparam logic [31:0] UNCACHED_KEEP = 32'h1FFF_F000;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic        reqValid,
  input  logic [3:0]  reqType,
  input  logic        reqStore,
  input  logic        reqNoMatch,
  input  logic        excLevel,
  input  logic        ivEnable,
  output exc_strobe_t strobe
);
  exc_type_e kind;

  always_comb begin
    kind = exc_type_e'(reqType);
    strobe.take    = reqValid;
    strobe.saveEpc = reqValid && !excLevel;
    strobe.offSel  = OFF_GENERAL;
    unique case (kind)
      TY_IRQ: begin
        strobe.code = 5'd0;
        if (ivEnable) strobe.offSel = OFF_IRQ;
      end
      TY_TLB_MOD:  strobe.code = 5'd1;
      TY_TLB_FLT: begin
        strobe.code = reqStore ? 5'd3 : 5'd2;
        if (reqNoMatch && !excLevel) strobe.offSel = OFF_REFILL;
      end
      TY_ADDR_FLT: strobe.code = reqStore ? 5'd5 : 5'd4;
      TY_SYSCALL:  strobe.code = 5'd8;
      TY_BREAK:    strobe.code = 5'd9;
      TY_RESV:     strobe.code = 5'd10;
      TY_OVF:      strobe.code = 5'd12;
      TY_TRAP:     strobe.code = 5'd13;
      TY_CACHE: begin
        strobe.code   = 5'd30;
        strobe.offSel = OFF_CACHE;
      end
      default:     strobe.code = 5'd10;
    endcase
  end
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          IRQ_LINES  = 8,
  parameter int          SPACE_W    = 5,
  parameter logic [31:0] BOOT_BASE  = 32'hBFC0_0000,
  parameter logic [31:0] RESET_BASE = 32'h8000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  exc_strobe_t          strobe,
  input  logic [ADDR_W-1:0]    reqPc,
  input  logic                 reqDelaySlot,
  input  logic [IRQ_LINES-1:0] irqPending,
  input  logic                 cfgWe,
  input  logic [1:0]           cfgSel,
  input  logic [31:0]          cfgData,
  output logic [ADDR_W-1:0]    epc,
  output logic                 branchDelay,
  output logic                 excLevel,
  output logic [4:0]           excCode,
  output logic [ADDR_W-1:0]    handlerAddr,
  output logic                 takenPulse,
  output logic                 ivEnable,
  output logic                 bootVec
);
  localparam int VEC_W  = $clog2(IRQ_LINES);
  localparam int PAGE_W = 12;
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [BASE_W-1:0]    baseHi;
  logic [IRQ_LINES-1:0] irqMask;
  logic [SPACE_W-1:0]   spacing;
  logic [IRQ_LINES-1:0] masked;
  logic [VEC_W-1:0]     vecNum;
  logic [ADDR_W-1:0]    offset;
  logic [ADDR_W-1:0]    handlerBase;
  logic [ADDR_W-1:0]    fullBase;

  assign masked   = irqPending & irqMask;
  assign fullBase = {baseHi, {PAGE_W{1'b0}}};

  always_comb begin
    vecNum = '0;
    for (int i = 0; i < IRQ_LINES; i++)
      if (masked[i]) vecNum = VEC_W'(i);
  end

  always_comb begin
    unique case (strobe.offSel)
      OFF_REFILL: offset = '0;
      OFF_CACHE:  offset = ADDR_W'(12'h100);
      OFF_IRQ:
        if (bootVec || spacing == '0) offset = ADDR_W'(12'h200);
        else offset = ADDR_W'(12'h200) +
                      ADDR_W'(vecNum) * (ADDR_W'(spacing) << 5);
      default:    offset = ADDR_W'(12'h180);
    endcase
    if (bootVec)
      handlerBase = ADDR_W'(BOOT_BASE) + ADDR_W'(12'h200);
    else if (strobe.offSel == OFF_CACHE)
      handlerBase = ADDR_W'(UNCACHED_BASE) | (fullBase & ADDR_W'(UNCACHED_KEEP));
    else
      handlerBase = fullBase;
  end

  // control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi   <= RESET_BASE[ADDR_W-1:PAGE_W];
      bootVec  <= 1'b1;
      irqMask  <= '0;
      ivEnable <= 1'b0;
      spacing  <= '0;
    end else if (cfgWe) begin
      unique case (cfgSel)
        2'd0: baseHi <= cfgData[ADDR_W-1:PAGE_W];
        2'd1: begin
          bootVec <= cfgData[1];
          irqMask <= cfgData[8 +: IRQ_LINES];
        end
        2'd2: begin
          ivEnable <= cfgData[0];
          spacing  <= cfgData[5 +: SPACE_W];
        end
        default: ;
      endcase
    end
  end

  // exception state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      epc         <= '0;
      branchDelay <= 1'b0;
      excLevel    <= 1'b0;
      excCode     <= '0;
      handlerAddr <= '0;
      takenPulse  <= 1'b0;
    end else begin
      takenPulse <= strobe.take;
      if (strobe.take) begin
        excLevel    <= 1'b1;
        excCode     <= strobe.code;
        handlerAddr <= handlerBase + offset;
      end else if (cfgWe && cfgSel == 2'd1) begin
        excLevel <= cfgData[0];
      end
      if (strobe.saveEpc) begin
        epc         <= reqDelaySlot ? reqPc - ADDR_W'(4) : reqPc;
        branchDelay <= reqDelaySlot;
      end
    end
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [3:0]  reqType,
  input  logic        reqStore,
  input  logic        reqNoMatch,
  input  logic [31:0] reqPc,
  input  logic        reqDelaySlot,
  input  logic [7:0]  irqPending,
  input  logic        cfgWe,
  input  logic [1:0]  cfgSel,
  input  logic [31:0] cfgData,
  output logic [31:0] epc,
  output logic        branchDelay,
  output logic        excLevel,
  output logic [4:0]  excCode,
  output logic [31:0] handlerAddr,
  output logic        takenPulse
);
  exc_strobe_t strobe;
  logic        ivEnable;
  logic        bootVec;

  exc_ctrl u_ctrl (
    .reqValid(reqValid), .reqType(reqType), .reqStore(reqStore),
    .reqNoMatch(reqNoMatch), .excLevel(excLevel), .ivEnable(ivEnable),
    .strobe(strobe)
  );

  exc_datapath #(.ADDR_W(32), .IRQ_LINES(8)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqPc(reqPc),
    .reqDelaySlot(reqDelaySlot), .irqPending(irqPending),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .epc(epc), .branchDelay(branchDelay), .excLevel(excLevel),
    .excCode(excCode), .handlerAddr(handlerAddr), .takenPulse(takenPulse),
    .ivEnable(ivEnable), .bootVec(bootVec)
  );
endmodule

// File: rtl/exc_vector_gen_chk.sv
module exc_vector_gen_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        excLevel,
  input logic [31:0] epc,
  input logic        takenPulse,
  input logic [4:0]  excCode,
  input logic [31:0] handlerAddr,
  input logic        bootVec
);
  assert_taken_after_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    takenPulse |-> $past(reqValid));

  assert_level_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> excLevel);

  assert_epc_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && excLevel) |=> $stable(epc));

  assert_cache_uncached_R8: assert property (@(posedge clk) disable iff (!rstN)
    (takenPulse && excCode == 5'd30 && !$past(bootVec)) |-> handlerAddr[31:29] == 3'b101);

  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    takenPulse |-> (excCode inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd8,
                                    5'd9, 5'd10, 5'd12, 5'd13, 5'd30}));
endmodule

bind exc_vector_gen exc_vector_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .excLevel(excLevel),
  .epc(epc), .takenPulse(takenPulse), .excCode(excCode),
  .handlerAddr(handlerAddr), .bootVec(bootVec)
);

// File: tb/exc_vector_gen_test.sv
module exc_vector_gen_test;
  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqStore = 0, reqNoMatch = 0, reqDelaySlot = 0;
  logic [3:0] reqType = 0;
  logic [31:0] reqPc = 0;
  logic [7:0] irqPending = 0;
  logic cfgWe = 0;
  logic [1:0] cfgSel = 0;
  logic [31:0] cfgData = 0;
  logic [31:0] epc, handlerAddr;
  logic branchDelay, excLevel, takenPulse;
  logic [4:0] excCode;

  int nChk = 0, nFail = 0;
  bit done = 0;

  // bench model of the control state
  logic [19:0] mBase = 20'h80000;
  logic mBoot = 1, mLevel = 0, mIv = 0, mBd = 0;
  logic [7:0] mMask = 0;
  logic [4:0] mSpace = 0;
  logic [31:0] mEpc = 0;

  always #4 clk = ~clk;

  exc_vector_gen uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] expCode(input int t, input bit st);
    case (t)
      0: return 5'd0;  1: return 5'd1;
      2: return st ? 5'd3 : 5'd2;
      3: return st ? 5'd5 : 5'd4;
      4: return 5'd8;  5: return 5'd9;  6: return 5'd10;
      7: return 5'd12; 8: return 5'd13; 9: return 5'd30;
      default: return 5'd10;
    endcase
  endfunction

  function automatic logic [31:0] expAddr(input int t, input bit nm, input logic [7:0] pend);
    logic [31:0] off, base;
    int v;
    off = 32'h180;
    if (t == 9) off = 32'h100;
    else if (t == 2 && nm && !mLevel) off = 32'h0;
    else if (t == 0 && mIv) begin
      v = 0;
      for (int i = 0; i < 8; i++) if (pend[i] & mMask[i]) v = i;
      if (mBoot || mSpace == 0) off = 32'h200;
      else off = 32'h200 + v * (mSpace * 32);
    end
    if (mBoot) base = 32'hBFC00200;
    else if (t == 9) base = 32'hA0000000 | ({mBase, 12'h0} & 32'h1FFFF000);
    else base = {mBase, 12'h0};
    return base + off;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWe = 0;
    case (sel)
      0: mBase = d[31:12];
      1: begin mLevel = d[0]; mBoot = d[1]; mMask = d[15:8]; end
      2: begin mIv = d[0]; mSpace = d[9:5]; end
      default: ;
    endcase
  endtask

  task automatic doReq(input int t, input bit st, input bit nm, input logic [31:0] pc,
                       input bit ds, input logic [7:0] pend, input string tag);
    logic [31:0] eAddr;
    logic [4:0] eCode;
    @(negedge clk);
    reqValid = 1; reqType = 4'(t); reqStore = st; reqNoMatch = nm;
    reqPc = pc; reqDelaySlot = ds; irqPending = pend;
    eAddr = expAddr(t, nm, pend);
    eCode = expCode(t, st);
    if (!mLevel) begin mEpc = ds ? pc - 4 : pc; mBd = ds; end
    mLevel = 1;
    @(negedge clk);
    reqValid = 0;
    check(takenPulse == 1, "R10 pulse", 32'(takenPulse), 1);
    check(excCode == eCode, "R2 code", 32'(excCode), 32'(eCode));
    check(handlerAddr == eAddr, tag, handlerAddr, eAddr);
    check(epc == mEpc, "R3 epc", epc, mEpc);
    check(branchDelay == mBd, "R3 bd", 32'(branchDelay), 32'(mBd));
    check(excLevel == 1, "R4 level", 32'(excLevel), 1);
    @(negedge clk);
    check(takenPulse == 0, "R10 pulse drop", 32'(takenPulse), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    check(takenPulse == 0 && excLevel == 0 && branchDelay == 0 && excCode == 0,
          "R1 flags", {takenPulse, excLevel, branchDelay, excCode}, 0);
    check(epc == 0 && handlerAddr == 0, "R1 regs", epc | handlerAddr, 0);

    // R9: boot vector set out of reset
    doReq(4, 0, 0, 32'h1000, 0, 0, "R9 boot base");
    // R3: level set, epc frozen
    doReq(3, 1, 0, 32'h2000, 1, 0, "R9 boot base again");
    // R11/R5: clear boot, load base
    wr(0, 32'h8123_4ABC);
    wr(1, 32'h0000_FF00);
    doReq(5, 0, 0, 32'h3000, 1, 0, "R5 general offset");
    // R6: refill with level set -> 0x180; then clear level -> 0x000
    doReq(2, 0, 1, 32'h3100, 0, 0, "R6 miss with level set");
    wr(1, 32'h0000_FF00);
    doReq(2, 1, 1, 32'h3200, 0, 0, "R6 refill offset");
    // R8 cache error
    wr(0, 32'hFFFF_F000);
    doReq(9, 0, 0, 32'h3300, 0, 0, "R8 cache base");
    // R7 vectored interrupt
    wr(2, {22'h0, 5'd3, 4'h0, 1'b1});
    wr(1, 32'h0000_3C00);
    doReq(0, 0, 0, 32'h3400, 0, 8'hF3, "R7 vectored");
    wr(1, 32'h0000_0000);
    doReq(0, 0, 0, 32'h3500, 0, 8'hFF, "R7 no masked line");
    // R11: sel 3 has no effect
    wr(3, 32'hFFFF_FFFF);
    wr(1, 32'h0000_0000);
    doReq(6, 0, 0, 32'h3600, 0, 0, "R11 sel3 ignored");

    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 3);
      if ($urandom_range(0, 2) == 0) begin
        logic [31:0] d = $urandom;
        if (sel == 1 && $urandom_range(0, 3) != 0) d[1] = 0;
        wr(2'(sel), d);
      end
      if ($urandom_range(0, 1) == 0) wr(1, {16'h0, mMask, 6'h0, 1'b0, 1'b0});
      doReq($urandom_range(0, 9), 1'($urandom), 1'($urandom),
            $urandom & 32'hFFFF_FFFC, 1'($urandom), 8'($urandom), "R7 R8 R9 random addr");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule